// File: doc/BRIEF.md
# Conditional Idle-Cycle Decision Unit

This helper sits beside the sequencer of a CPU core. Whenever the sequencer reaches a point in an instruction where an internal (non-bus) penalty cycle may be needed, it raises a query and names which rule applies. There are four kinds of query:

- a direct-page access, which is penalised when the direct register's low byte is nonzero;
- an indexed access, which is penalised for wide index registers or for a page crossing;
- a taken branch, which is penalised only in emulation mode on a page crossing;
- the idle cycle of a short implied-mode instruction.

For the implied-mode case the unit also decides whether a pending interrupt turns that idle cycle into a dummy bus read at the current program counter. That dummy read does not advance the counter.

All decisions are sampled on the query cycle and presented one clock later on registered outputs. A saturating counter totals the penalty cycles inserted since the last instruction start, so the cycle count of an instruction can be checked at the ports. Opcode sequencing and interrupt vectoring belong to the surrounding core.

Top module: `idle_cycle_decider`

## Requirements
- R1: A query of kind 0 (direct) inserts a cycle exactly when `dir_low` is nonzero.
- R2: A query of kind 1 (indexed) inserts a cycle exactly when `idx_narrow` is 0, or when `base_addr` and `idx_addr` differ in the bits above the low LOW_W bits.
- R3: A query of kind 2 (branch) inserts a cycle exactly when `emu_mode` is 1 and `pc` and `br_target` differ in the bits above the low LOW_W bits.
- R4: A query of kind 3 (implied) with `irq_pending` high inserts a cycle that is a bus read: `bus_read`=1, `internal_cyc`=0, and `read_addr` equals `pc` itself, not pc+1.
- R5: Every other inserted cycle, including kind 3 with no pending interrupt, shows `internal_cyc`=1 with `bus_read`=0 and `read_addr`=0.
- R6: Each decision appears on the outputs in the clock cycle after the query. A cycle without `q_valid` yields `idle_insert`=0, `bus_read`=0, `internal_cyc`=0 and `read_addr`=0.
- R7: `idle_count` is set to the current query's insertion (0 or 1) when `instr_start` is high. Otherwise it adds one per inserted cycle and holds at 2^CNT_W-1.
- R8: While `rst` is high, all outputs are driven to zero on the next clock edge.
- R9: `irq_pending` has no effect on queries of kinds 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_start | input | 1 | First cycle of a new instruction; restarts the count |
| q_valid | input | 1 | A penalty-cycle query is present this cycle |
| q_kind | input | 2 | 0 direct, 1 indexed, 2 branch, 3 implied |
| dir_low | input | LOW_W | Low byte of the direct register |
| idx_narrow | input | 1 | 1 when the index registers are narrow |
| base_addr | input | ADDR_W | Address before indexing |
| idx_addr | input | ADDR_W | Address after indexing |
| pc | input | ADDR_W | Current program counter |
| br_target | input | ADDR_W | Branch destination |
| emu_mode | input | 1 | Emulation mode flag |
| irq_pending | input | 1 | An interrupt will be taken after this instruction |
| idle_insert | output | 1 | A penalty cycle is inserted (registered) |
| bus_read | output | 1 | The inserted cycle is a dummy bus read |
| internal_cyc | output | 1 | The inserted cycle has no bus access |
| read_addr | output | ADDR_W | Address of the dummy read, else 0 |
| idle_count | output | CNT_W | Inserted cycles since instruction start |

## Verification
The bench builds the unit with ADDR_W=8, LOW_W=4 and CNT_W=3. With these widths a page is sixteen addresses, so every direct low value, every base address against sixteen index offsets, and every program counter against sixteen branch targets can be swept exhaustively in a few thousand cycles. The three-bit counter reaches saturation within a handful of inserted cycles, which makes the hold at seven and the clear on instruction start frequent events. In the same sweeps, the pending-interrupt input is toggled under the non-implied kinds.

// File: rtl/icd_pkg.sv
package icd_pkg;
  typedef enum logic [1:0] {
    Q_DIRECT  = 2'd0,
    Q_INDEX   = 2'd1,
    Q_BRANCH  = 2'd2,
    Q_IMPLIED = 2'd3
  } query_kind_t;
endpackage

// File: rtl/icd_page_cmp.sv
module icd_page_cmp #(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  output logic              differ
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic [HI_W-1:0] a_hi, b_hi;

  always_comb begin
    a_hi   = a[ADDR_W-1:LOW_W];
    b_hi   = b[ADDR_W-1:LOW_W];
    differ = (a_hi != b_hi);
  end
endmodule

// File: rtl/icd_rules.sv
module icd_rules
  import icd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8
) (
  input  logic              q_valid,
  input  query_kind_t       kind,
  input  logic [LOW_W-1:0]  dir_low,
  input  logic              idx_narrow,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] idx_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              emu_mode,
  input  logic              irq_pending,
  output logic              ins,
  output logic              as_read,
  output logic [ADDR_W-1:0] rd_addr
);
  logic idx_cross, br_cross;

  icd_page_cmp #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_idx_cmp (
    .a(base_addr), .b(idx_addr), .differ(idx_cross)
  );

  icd_page_cmp #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_br_cmp (
    .a(pc), .b(br_target), .differ(br_cross)
  );

  always_comb begin
    ins     = 1'b0;
    as_read = 1'b0;
    rd_addr = '0;
    if (q_valid) begin
      unique case (kind)
        Q_DIRECT:  ins = |dir_low;
        Q_INDEX:   ins = !idx_narrow || idx_cross;
        Q_BRANCH:  ins = emu_mode && br_cross;
        Q_IMPLIED: begin
          ins     = 1'b1;
          as_read = irq_pending;
          // dummy read goes to the counter as-is; no increment
          rd_addr = irq_pending ? pc : '0;
        end
        default:   ins = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/icd_counter.sv
module icd_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (clear)
      count <= inc ? CNT_ONE : '0;
    else if (inc && count != CNT_MAX)
      count <= count + CNT_ONE;
  end

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(clear) && !$past(inc) |-> count == '0);

  p_sat_r7: assert property (@(posedge clk) disable iff (rst)
    $past(count) == CNT_MAX && !$past(clear) && !$past(rst) |-> count == CNT_MAX);
endmodule

// File: rtl/idle_cycle_decider.sv
module idle_cycle_decider
  import icd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_start,
  input  logic              q_valid,
  input  logic [1:0]        q_kind,
  input  logic [LOW_W-1:0]  dir_low,
  input  logic              idx_narrow,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] idx_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              emu_mode,
  input  logic              irq_pending,
  output logic              idle_insert,
  output logic              bus_read,
  output logic              internal_cyc,
  output logic [ADDR_W-1:0] read_addr,
  output logic [CNT_W-1:0]  idle_count
);
  logic              ins_c, rd_c;
  logic [ADDR_W-1:0] addr_c;

  icd_rules #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_rules (
    .q_valid    (q_valid),
    .kind       (query_kind_t'(q_kind)),
    .dir_low    (dir_low),
    .idx_narrow (idx_narrow),
    .base_addr  (base_addr),
    .idx_addr   (idx_addr),
    .pc         (pc),
    .br_target  (br_target),
    .emu_mode   (emu_mode),
    .irq_pending(irq_pending),
    .ins        (ins_c),
    .as_read    (rd_c),
    .rd_addr    (addr_c)
  );

  icd_counter #(.CNT_W(CNT_W)) u_count (
    .clk  (clk),
    .rst  (rst),
    .clear(instr_start),
    .inc  (ins_c),
    .count(idle_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_insert  <= 1'b0;
      bus_read     <= 1'b0;
      internal_cyc <= 1'b0;
      read_addr    <= '0;
    end else begin
      idle_insert  <= ins_c;
      bus_read     <= rd_c;
      internal_cyc <= ins_c && !rd_c;
      read_addr    <= addr_c;
    end
  end

  p_direct_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(q_valid && q_kind == 2'd0 && dir_low == '0) |-> !idle_insert);

  p_narrow_same_r2: assert property (@(posedge clk) disable iff (rst)
    $past(q_valid && q_kind == 2'd1 && idx_narrow &&
          base_addr[ADDR_W-1:LOW_W] == idx_addr[ADDR_W-1:LOW_W]) |-> !idle_insert);

  p_branch_native_r3: assert property (@(posedge clk) disable iff (rst)
    $past(q_valid && q_kind == 2'd2 && !emu_mode) |-> !idle_insert);

  p_read_at_pc_r4: assert property (@(posedge clk) disable iff (rst)
    $past(q_valid && q_kind == 2'd3 && irq_pending) |->
      bus_read && !internal_cyc && read_addr == $past(pc));

  p_internal_only_r5: assert property (@(posedge clk) disable iff (rst)
    $past(q_valid && q_kind == 2'd3 && !irq_pending) |-> internal_cyc && !bus_read);

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!q_valid) |-> !idle_insert && !bus_read && !internal_cyc);
endmodule

// File: tb/sim_idle_cycle_decider.sv
module sim_idle_cycle_decider;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_start = 1'b0, q_valid = 1'b0;
  logic [1:0] q_kind = '0;
  logic [LW-1:0] dir_low = '0;
  logic idx_narrow = 1'b0, emu_mode = 1'b0, irq_pending = 1'b0;
  logic [AW-1:0] base_addr = '0, idx_addr = '0, pc = '0, br_target = '0;
  logic idle_insert, bus_read, internal_cyc;
  logic [AW-1:0] read_addr;
  logic [CW-1:0] idle_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_cycle_decider #(.ADDR_W(AW), .LOW_W(LW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .instr_start(instr_start), .q_valid(q_valid),
    .q_kind(q_kind), .dir_low(dir_low), .idx_narrow(idx_narrow),
    .base_addr(base_addr), .idx_addr(idx_addr), .pc(pc), .br_target(br_target),
    .emu_mode(emu_mode), .irq_pending(irq_pending),
    .idle_insert(idle_insert), .bus_read(bus_read), .internal_cyc(internal_cyc),
    .read_addr(read_addr), .idle_count(idle_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive a query, wait one clock, check outputs.
  task automatic query(input bit st, input bit vld, input int k, input int dl,
                       input bit nar, input int ba, input int ia, input int p,
                       input int bt, input bit emu, input bit irq, input string req);
    bit ins, rd;
    int addr;
    logic [10:0] act, exp;
    instr_start = st; q_valid = vld; q_kind = 2'(k); dir_low = LW'(dl);
    idx_narrow = nar; base_addr = AW'(ba); idx_addr = AW'(ia); pc = AW'(p);
    br_target = AW'(bt); emu_mode = emu; irq_pending = irq;
    ins = 1'b0; rd = 1'b0;
    if (vld) begin
      case (k)
        0: ins = (dl % (1 << LW)) != 0;
        1: ins = !nar || ((ba % 256) >> LW) != ((ia % 256) >> LW);
        2: ins = emu && ((p % 256) >> LW) != ((bt % 256) >> LW);
        default: begin ins = 1'b1; rd = irq; end
      endcase
    end
    addr = rd ? (p % 256) : 0;
    if (st) exp_cnt = ins ? 1 : 0;
    else if (ins && exp_cnt < CMAX) exp_cnt++;
    @(negedge clk);
    act = {idle_insert, bus_read, internal_cyc, read_addr};
    exp = {ins, rd, ins && !rd, AW'(addr)};
    check(act == exp, req, int'(act), int'(exp));
    check(int'(idle_count) == exp_cnt, "R7", int'(idle_count), exp_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check({idle_insert, bus_read, internal_cyc} == 3'b0 && read_addr == '0 && idle_count == '0,
          "R8", int'({idle_insert, bus_read, internal_cyc, read_addr, idle_count}), 0);
    rst = 1'b0;
    exp_cnt = 0;

    // R6: no query gives quiet outputs
    for (int i = 0; i < 4; i++)
      query(i == 0, 1'b0, i, 5, 1'b0, 0, 255, 3, 200, 1'b1, 1'b1, "R6");

    // R1 with R9: all direct low values, interrupt toggled
    for (int d = 0; d < (1 << LW); d++)
      for (int q = 0; q < 2; q++)
        query((d % 5) == 0 && q == 0, 1'b1, 0, d, 1'b1, 0, 0, 0, 0, 1'b0, q[0], "R1/R9");

    // R2 with R9: every base against sixteen offsets, both index widths
    for (int b = 0; b < 256; b++)
      for (int o = 0; o < 16; o++)
        for (int n = 0; n < 2; n++)
          query(o == 0 && n == 0, 1'b1, 1, 0, n[0], b, (b + o) % 256, 0, 0, 1'b0, o[0], "R2/R9");

    // R3 with R9: every pc against sixteen targets, both modes
    for (int p = 0; p < 256; p++)
      for (int t = 0; t < 16; t++)
        for (int e = 0; e < 2; e++)
          query(t == 0 && e == 0, 1'b1, 2, 0, 1'b1, 0, 0, p, (t * 17 + p) % 256, e[0],
                t[1], "R3/R9");

    // R4 and R5: implied idle cycle at every pc
    for (int p = 0; p < 256; p++) begin
      query(1'b1, 1'b1, 3, 0, 1'b1, 0, 0, p, 0, p[0], 1'b1, "R4");
      query(1'b0, 1'b1, 3, 0, 1'b1, 0, 0, p, 0, p[0], 1'b0, "R5");
    end

    // R7: saturation, then clear by a start with no insertion
    for (int i = 0; i < 10; i++)
      query(i == 0, 1'b1, 3, 0, 1'b0, 0, 0, 9, 0, 1'b0, 1'b0, "R7");
    query(1'b1, 1'b1, 0, 0, 1'b0, 0, 0, 0, 0, 1'b0, 1'b0, "R7");
    query(1'b0, 1'b0, 0, 0, 1'b0, 0, 0, 0, 0, 1'b0, 1'b0, "R6");

    // R8: reset mid-run clears outputs and count
    query(1'b0, 1'b1, 3, 0, 1'b0, 0, 0, 33, 0, 1'b0, 1'b1, "R4");
    rst = 1'b1;
    @(negedge clk);
    check({idle_insert, bus_read, internal_cyc} == 3'b0 && read_addr == '0 && idle_count == '0,
          "R8", int'({idle_insert, bus_read, internal_cyc, read_addr, idle_count}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule